// File: doc/BRIEF.md
# GPIO Interrupt Slot Router

This block turns general-purpose input lines into interrupt requests. Software picks, for each of 32 interrupt slots, one GPIO line out of 123, together with an enable bit. It also gives each slot a sense mode: rising edge, falling edge, high level or low level. Each slot owns a sticky status bit. While the slot is enabled, that status bit drives an active-high, level-type request toward an upstream interrupt controller. Software acknowledges an event by writing a zero to the slot's status bit.

All GPIO lines pass through a shared two-flop synchronizer before any slot samples them. A slot whose enable bit is clear, or whose index points past the last GPIO line, sees its input as zero. A write that changes a slot's select byte discards that slot's edge history, so re-routing a slot cannot by itself create an event. Registers are reached through a simple single-cycle write port with a combinational read port.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and every request output is low.
- R2: The select register at address 0x30 + 4n holds four bytes, and byte k (bits 8k+7..8k) belongs to slot 4n+k. In that byte, bit 7 enables the slot and bits 6..0 hold the GPIO index. Written values read back unchanged.
- R3: Sense fields are two bits wide. Slot k (0..15) uses bits 2k+1..2k at address 0x24, and slot 16+k uses bits 2k+1..2k at address 0x28. Written values read back unchanged.
- R4: A sense value of 0 sets the status bit on a rising edge of the selected line, 1 on a falling edge, 2 while the line is high and 3 while it is low.
- R5: A GPIO change driven between clock edges sets the status bit on the third rising clock edge after the change, and not on an earlier edge.
- R6: The status register sits at address 0x20, with bit i for slot i. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R7: If an event arrives in the same cycle as a write that clears its status bit, the bit stays set.
- R8: A slot's request equals its status bit while the slot is enabled and is low while it is disabled. A disabled slot never sets its status bit.
- R9: A GPIO index of 123 or above reads the input as constant 0.
- R10: Changing a slot's select byte does not set its status bit, even when the old and new lines differ in level.
- R11: In a level mode, a status bit cleared while the level is still active is set again. Once the level is gone, a clear keeps the bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gpio_in | input | 123 | Asynchronous GPIO lines |
| irq_req | output | 32 | Level-high request, one per slot |

## Verification
A register write is taken at the rising edge that follows the strobe, so its readback is sampled at the next falling edge. A GPIO change first passes through two synchronizer flops and is then registered into the status bit, so the status bit and the request become visible only after the third rising edge. The bench samples one edge early, where it expects 0, and then exactly on time. The test where an event meets a clear places the clear write on that third edge. Tests that expect no status change wait well past the three-edge latency before they look.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types for the GPIO interrupt slot router.
// Assumes a byte-addressed register space with 32-bit registers.
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        SNS_RISE = 2'd0,
        SNS_FALL = 2'd1,
        SNS_HIGH = 2'd2,
        SNS_LOW  = 2'd3
    } sense_e;

    localparam int STAT_OFS   = 'h20;
    localparam int SENSE_OFS  = 'h24;
    localparam int SEL_OFS    = 'h30;
    localparam int SEL_EN_BIT = 7;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous lines.
// Assumes each line is a slow level signal; no bus coherence is implied.
module gpio_in_sync #(
    parameter int WIDTH  = 123,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], async_in};
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_slot.sv
// One interrupt slot: picks a synchronized GPIO line and detects the event
// selected by its sense mode. Assumes 2**IDX_W >= NUM_GPIO. cfg_chg is
// high for one cycle after the select byte changed, and while it is high
// detection is suppressed so that the history can settle on the new line.
module gpio_irq_slot
    import gpio_irq_pkg::*;
#(
    parameter int NUM_GPIO = 123,
    parameter int IDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] gpio_s,
    input  logic [IDX_W:0]      sel,
    input  logic [1:0]          sense,
    input  logic                cfg_chg,
    output logic                evt
);
    localparam int PAD_W = 2 ** IDX_W;

    logic [PAD_W-1:0] padded;
    logic             en;
    logic             cur;
    logic             prev_q;

    // Widen the line vector so that indices beyond the last line read 0.
    always_comb begin
        padded                 = '0;
        padded[NUM_GPIO-1:0]   = gpio_s;
    end

    assign en  = sel[IDX_W];
    assign cur = en & padded[sel[IDX_W-1:0]];

    // Track the previous sample of the selected line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Decode the event for the configured sense mode.
    always_comb begin
        evt = 1'b0;
        if (en && !cfg_chg) begin
            unique case (sense_e'(sense))
                SNS_RISE: evt = cur & ~prev_q;
                SNS_FALL: evt = ~cur & prev_q;
                SNS_HIGH: evt = cur;
                SNS_LOW:  evt = ~cur;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Register file: per-slot select bytes, packed sense fields and sticky
// status bits, with a single-cycle write port and a combinational read.
// Assumes NUM_SLOTS <= DATA_W and a select byte of IDX_W+1 == 8 bits.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_SLOTS-1:0]        evt,
    output logic [NUM_SLOTS-1:0][7:0]   sel_q,
    output logic [NUM_SLOTS-1:0][1:0]   sense_q,
    output logic [NUM_SLOTS-1:0]        status_q,
    output logic [NUM_SLOTS-1:0]        cfg_chg
);
    localparam int BYTES_PER_REG  = DATA_W / 8;
    localparam int FIELDS_PER_REG = DATA_W / 2;

    logic [NUM_SLOTS-1:0] sel_hit;
    logic [NUM_SLOTS-1:0] sns_hit;
    logic                 stat_hit;

    assign stat_hit = bus_addr == ADDR_W'(STAT_OFS);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int SEL_ADDR = SEL_OFS + 4 * (i / BYTES_PER_REG);
        localparam int SNS_ADDR = SENSE_OFS + 4 * (i / FIELDS_PER_REG);
        localparam int BYTE_LSB = 8 * (i % BYTES_PER_REG);
        localparam int FLD_LSB  = 2 * (i % FIELDS_PER_REG);

        assign sel_hit[i] = bus_addr == ADDR_W'(SEL_ADDR);
        assign sns_hit[i] = bus_addr == ADDR_W'(SNS_ADDR);

        // Load the slot's select byte and flag a real change of it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[i]   <= '0;
                cfg_chg[i] <= 1'b0;
            end else begin
                cfg_chg[i] <= bus_wr && sel_hit[i] &&
                              (bus_wdata[BYTE_LSB +: 8] != sel_q[i]);
                if (bus_wr && sel_hit[i]) sel_q[i] <= bus_wdata[BYTE_LSB +: 8];
            end
        end

        // Load the slot's sense field.
        always_ff @(posedge clk) begin
            if (!rst_n)                    sense_q[i] <= '0;
            else if (bus_wr && sns_hit[i]) sense_q[i] <= bus_wdata[FLD_LSB +: 2];
        end
    end

    // Sticky status: zeros written clear, new events win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((bus_wr && stat_hit) ?
                                 (status_q & bus_wdata[NUM_SLOTS-1:0]) : status_q) | evt;
    end

    // Assemble read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (stat_hit) bus_rdata[NUM_SLOTS-1:0] = status_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel_hit[i]) bus_rdata[8 * (i % BYTES_PER_REG) +: 8] = sel_q[i];
            if (sns_hit[i]) bus_rdata[2 * (i % FIELDS_PER_REG) +: 2] = sense_q[i];
        end
    end
endmodule

// File: rtl/gpio_irq_router.sv
// Top level: synchronizes the GPIO lines, runs one detector per slot and
// drives a level request per enabled slot from its status bit.
// Assumes the upstream controller takes level-high requests.
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_GPIO    = 123,
    parameter int NUM_SLOTS   = 32,
    parameter int IDX_W       = 7,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_GPIO-1:0]  gpio_in,
    output logic [NUM_SLOTS-1:0] irq_req
);
    logic [NUM_GPIO-1:0]             gpio_s;
    logic [NUM_SLOTS-1:0][7:0]       sel_q;
    logic [NUM_SLOTS-1:0][1:0]       sense_q;
    logic [NUM_SLOTS-1:0]            status_q;
    logic [NUM_SLOTS-1:0]            cfg_chg;
    logic [NUM_SLOTS-1:0]            evt;
    logic [NUM_SLOTS-1:0]            slot_en;

    gpio_in_sync #(.WIDTH(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gpio_in),
        .sync_out (gpio_s)
    );

    gpio_irq_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .sel_q     (sel_q),
        .sense_q   (sense_q),
        .status_q  (status_q),
        .cfg_chg   (cfg_chg)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        gpio_irq_slot #(.NUM_GPIO(NUM_GPIO), .IDX_W(IDX_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .gpio_s  (gpio_s),
            .sel     (sel_q[i][IDX_W:0]),
            .sense   (sense_q[i]),
            .cfg_chg (cfg_chg[i]),
            .evt     (evt[i])
        );
        assign slot_en[i] = sel_q[i][SEL_EN_BIT];
    end

    assign irq_req = status_q & slot_en;
endmodule

// File: rtl/gpio_irq_router_chk.sv
// Checker for gpio_irq_router, bound to every instance of the top.
// Observes the bus, the register state and the request outputs.
module gpio_irq_router_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [NUM_SLOTS-1:0][7:0] sel_q,
    input logic [NUM_SLOTS-1:0]      status_q,
    input logic [NUM_SLOTS-1:0]      irq_req
);
    localparam int BYTES_PER_REG = DATA_W / 8;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && irq_req == '0)); // R1

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        localparam int SEL_ADDR = SEL_OFS + 4 * (i / BYTES_PER_REG);
        localparam int BYTE_LSB = 8 * (i % BYTES_PER_REG);

        AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(SEL_ADDR))
            |=> sel_q[i] == $past(bus_wdata[BYTE_LSB +: 8])); // R2

        AST_FALL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_q[i])
            |-> $past(bus_wr && bus_addr == ADDR_W'(STAT_OFS) && !bus_wdata[i])); // R6

        AST_REQ_NEEDS_STATUS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> (status_q[i] && sel_q[i][SEL_EN_BIT])); // R8

        AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> $past(sel_q[i][SEL_EN_BIT])); // R8
    end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .status_q  (status_q),
    .irq_req   (irq_req)
);

// File: tb/test_gpio_irq_router.sv
// Self-checking bench: a vector table of slot, line, mode and levels,
// followed by directed tests for reset and corner cases.
module test_gpio_irq_router;
    typedef struct packed {
        logic [4:0] slot;
        logic [6:0] idx;
        logic [1:0] mode;
        logic       init;
        logic       fin;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  7'd0,   2'd0, 1'b0, 1'b1},
        '{5'd5,  7'd17,  2'd0, 1'b1, 1'b0},
        '{5'd15, 7'd122, 2'd1, 1'b1, 1'b0},
        '{5'd16, 7'd64,  2'd1, 1'b0, 1'b1},
        '{5'd22, 7'd33,  2'd2, 1'b0, 1'b1},
        '{5'd31, 7'd100, 2'd2, 1'b0, 1'b0},
        '{5'd9,  7'd7,   2'd3, 1'b1, 1'b0},
        '{5'd27, 7'd90,  2'd3, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [122:0] gpio = '0;
    logic [31:0]  irq_req;
    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    gpio_irq_router i_gpio_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio),
        .irq_req   (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic        exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of all registers and requests
        rd(8'h20, r); check("R1 status", r, 0);
        rd(8'h24, r); check("R1 sense lo", r, 0);
        rd(8'h28, r); check("R1 sense hi", r, 0);
        for (int n = 0; n < 8; n++) begin
            rd(8'h30 + 8'(4 * n), r); check("R1 select", r, 0);
        end
        check("R1 irq_req", irq_req, 0);

        // Vector table: R4 modes, R5 latency, R8 request
        for (int v = 0; v < NV; v++) begin
            logic [7:0] sns_a;
            logic [7:0] sel_a;
            vec_t t;
            t = VECS[v];
            sns_a = (t.slot < 16) ? 8'h24 : 8'h28;
            sel_a = 8'h30 + 8'(4 * (t.slot / 4));
            gpio = '0; gpio[t.idx] = t.init;
            idle(4);
            wr(sns_a, 32'(t.mode) << (2 * (t.slot % 16)));
            wr(sel_a, 32'({1'b1, t.idx}) << (8 * (t.slot % 4)));
            idle(4);
            wr(8'h20, 32'h0);
            rd(8'h20, r); check("R6 cleared before stimulus", 32'(r[t.slot]), 0);
            gpio[t.idx] = t.fin;
            @(posedge clk); @(posedge clk); @(negedge clk);
            rd(8'h20, r); check("R5 not yet set after two edges", 32'(r[t.slot]), 0);
            @(posedge clk); @(negedge clk);
            case (t.mode)
                2'd0: exp = !t.init && t.fin;
                2'd1: exp = t.init && !t.fin;
                2'd2: exp = t.fin;
                default: exp = !t.fin;
            endcase
            rd(8'h20, r); check("R4 status after third edge", 32'(r[t.slot]), 32'(exp));
            check("R8 request follows status", 32'(irq_req[t.slot]), 32'(exp));
            wr(sel_a, 0); wr(sns_a, 0); wr(8'h20, 0);
        end
        gpio = '0;

        // R2 and R3: field readback
        wr(8'h3C, 32'hA503807F);
        rd(8'h3C, r); check("R2 select readback", r, 32'hA503807F);
        wr(8'h28, 32'hC0000001);
        rd(8'h28, r); check("R3 sense hi readback", r, 32'hC0000001);
        wr(8'h24, 32'h00000080);
        rd(8'h24, r); check("R3 sense lo readback", r, 32'h00000080);
        wr(8'h3C, 0); wr(8'h28, 0); wr(8'h24, 0); wr(8'h20, 0);

        // R9: out-of-range index reads as 0
        gpio = '1;
        wr(8'h24, 32'h2 << 6);
        wr(8'h30, 32'hFD << 24);
        idle(6);
        rd(8'h20, r); check("R9 level-high on index 125 stays clear", 32'(r[3]), 0);
        wr(8'h24, 32'h3 << 6);
        idle(6);
        rd(8'h20, r); check("R9 level-low on index 125 sets", 32'(r[3]), 1);
        wr(8'h30, 0); wr(8'h24, 0); wr(8'h20, 0);

        // R8: disabled slot
        wr(8'h24, 32'h2 << 8);
        wr(8'h34, 32'h05);
        idle(6);
        rd(8'h20, r); check("R8 disabled slot no status", 32'(r[4]), 0);
        check("R8 disabled slot no request", 32'(irq_req[4]), 0);
        wr(8'h34, 32'h85);
        idle(6);
        check("R8 enabled slot requests", 32'(irq_req[4]), 1);

        // R11: level re-asserts after clear while active
        wr(8'h20, 0);
        rd(8'h20, r); check("R11 status re-set while level active", 32'(r[4]), 1);
        wr(8'h34, 32'h05);
        check("R8 request drops on disable", 32'(irq_req[4]), 0);
        rd(8'h20, r); check("R8 status kept on disable", 32'(r[4]), 1);
        wr(8'h20, 0);
        idle(6);
        rd(8'h20, r); check("R8 disabled slot stays clear", 32'(r[4]), 0);
        wr(8'h34, 32'h85);
        idle(4);
        gpio[5] = 1'b0;
        idle(4);
        wr(8'h20, 0);
        idle(4);
        rd(8'h20, r); check("R11 clear sticks once level gone", 32'(r[4]), 0);
        wr(8'h34, 0); wr(8'h24, 0); wr(8'h20, 0);

        // R10: reselecting a different line makes no edge
        gpio = '0; gpio[1] = 1'b1;
        wr(8'h30, 32'h82);
        idle(6);
        wr(8'h20, 0);
        wr(8'h30, 32'h81);
        idle(6);
        rd(8'h20, r); check("R10 rising mode, switch to high line", 32'(r[0]), 0);
        wr(8'h24, 32'h1);
        wr(8'h30, 32'h82);
        idle(6);
        rd(8'h20, r); check("R10 falling mode, switch to low line", 32'(r[0]), 0);
        wr(8'h30, 0); wr(8'h24, 0); wr(8'h20, 0);

        // R6 and R7: writing ones, and an edge colliding with a clear
        gpio = '0;
        wr(8'h30, 32'h83);
        idle(4);
        gpio[3] = 1'b1;
        idle(5);
        wr(8'h20, 32'hFFFFFFFF);
        rd(8'h20, r); check("R6 writing one keeps status", 32'(r[0]), 1);
        gpio[3] = 1'b0;
        idle(5);
        @(negedge clk);
        gpio[3] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h20, r); check("R7 edge beats clear", 32'(r[0]), 1);
        wr(8'h20, 0);
        rd(8'h20, r); check("R6 writing zero clears", 32'(r[0]), 0);
        wr(8'h30, 0);

        finish_run();
    end
endmodule